// File: doc/BRIEF.md
# Keyed Configuration Port Register File

This block holds a byte-wide configuration space that the host reaches through two I/O addresses. The lower address is an index port and the upper one is a data port. Writing an index selects a register, and later data-port accesses read or write that register. The space is closed after reset. The host opens it by writing an entry key twice in succession to the index port, and closes it again by writing an exit key.

Index values below 0x30 form a global area that every device shares. This area holds a logical-device selector, read-only identification bytes, and a group of pin-routing bytes that are exported to the pad logic. Index values of 0x30 and above belong to the logical device currently chosen by the selector. Each device has its own enable bit, a 16-bit base address and a small bank of private bytes, and all of these are exported for the device logic that sits behind the bank.

Reads are registered. The byte returned belongs to the access strobed in the previous cycle.

Top module: `cfgport_regfile`

## Requirements
- R1: After reset the space is closed. The selector, the pin-routing bytes, every device enable, base and private byte are all zero.
- R2: While the space is closed, data-port writes change nothing, and reads of either port return 0xFF. While the space is open, an index-port read returns the current index.
- R3: The space opens only after two consecutive index-port writes of 0x87. Any other index-port write after the first 0x87 returns the block to the fully closed state.
- R4: An index-port write of 0xAA while the space is open closes it. The 0xAA is not stored as an index.
- R5: Identification bytes are read-only and are laid out high byte first: 0x20 holds the device ID high byte, 0x21 its low byte, 0x22 the revision, 0x23 the manufacturer ID high byte (0x19) and 0x24 its low byte (0x34). Writes to these bytes have no effect.
- R6: Index 0x07 is a read/write selector. Its value chooses which device bank answers at index 0x30 and above, and each bank keeps its own contents.
- R7: Bit 0 of index 0x30 is the selected device's enable and drives `dev_enable[n]`. Bits 7:1 of that register read as zero.
- R8: Index 0x60 is the high byte and index 0x61 the low byte of the selected device's base address, which drives `dev_base[n*16 +: 16]`.
- R9: Indexes 0x26 to 0x2C are shared pin-routing bytes exported on `mux_regs[(i-0x26)*8 +: 8]`. The selector value does not change which byte is read.
- R10: When the selector is at or above NUM_DEV, or when the index maps to nothing, a read returns 0xFF and a write has no effect. Private bytes occupy indexes 0xF0 to 0xF0+NUM_PRIV-1.
- R11: A port read strobed in cycle N sets `io_rd_valid` with the data in cycle N+1. A read and a write of the data port in the same cycle return the value held before the write, and the write still takes effect.
- R12: Accesses to any address other than the base (0x2E, or 0x4E when USE_ALT_BASE is set) and base+1 are ignored. This includes key values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rd_valid | output | 1 | Read data valid, one cycle after a port read |
| cfg_open | output | 1 | Configuration space is open |
| ldev_sel | output | 8 | Current logical-device selector |
| mux_regs | output | 56 | Shared pin-routing bytes, 0x26 at the bottom |
| dev_enable | output | NUM_DEV | Per-device enable bits |
| dev_base | output | NUM_DEV*16 | Per-device base addresses |
| dev_priv | output | NUM_DEV*NUM_PRIV*8 | Per-device private bytes |

## Verification
The data port can be read and written in the same cycle. That cycle must return the register's old contents, and the new byte must appear both on the exported bits and on the following read. The bench raises both strobes together on a pin-routing byte and checks the returned byte and the later read back. A second collision is the bank swap: when the selector changes, the next access must land in the new bank only. The bench writes different values to two devices, switches between them and reads both back.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} unlock_st_t;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;
  localparam logic [7:0] IDX_LDSEL   = 8'h07;
  localparam logic [7:0] IDX_ID_LO   = 8'h20;
  localparam logic [7:0] IDX_ID_HI   = 8'h24;
  localparam logic [7:0] IDX_MUX_LO  = 8'h26;
  localparam logic [7:0] IDX_MUX_HI  = 8'h2C;
  localparam logic [7:0] IDX_DEV_EN  = 8'h30;
  localparam logic [7:0] IDX_BASE_H  = 8'h60;
  localparam logic [7:0] IDX_BASE_L  = 8'h61;
  localparam logic [7:0] IDX_PRIV_LO = 8'hF0;
  localparam int         NUM_MUX     = int'(IDX_MUX_HI) - int'(IDX_MUX_LO) + 1;

  function automatic logic in_span(input logic [7:0] v, input int lo, input int hi);
    return (int'(v) >= lo) && (int'(v) <= hi);
  endfunction

  // identification byte for an index in the ID span, high byte first
  function automatic logic [7:0] id_byte(input logic [7:0] idx, input logic [15:0] dev,
                                         input logic [7:0] rev, input logic [15:0] mfg);
    case (idx)
      8'h20:   return dev[15:8];
      8'h21:   return dev[7:0];
      8'h22:   return rev;
      8'h23:   return mfg[15:8];
      8'h24:   return mfg[7:0];
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgport_unlock.sv
`timescale 1ns/1ps
module cfgport_unlock
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       key_hit,
  output logic       exit_hit,
  output logic       idx_load
);
  unlock_st_t st_q, st_d;

  assign key_hit  = idx_wr && (wdata == KEY_ENTER) && (st_q != ST_OPEN);
  assign exit_hit = idx_wr && (wdata == KEY_EXIT) && (st_q == ST_OPEN);
  assign idx_load = idx_wr && (wdata != KEY_EXIT) && (st_q == ST_OPEN);
  assign open     = (st_q == ST_OPEN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_LOCKED: if (key_hit) st_d = ST_KEY1;
      ST_KEY1:   if (idx_wr) st_d = key_hit ? ST_OPEN : ST_LOCKED;
      ST_OPEN:   if (exit_hit) st_d = ST_LOCKED;
      default:   st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
endmodule

// File: rtl/cfgport_globals.sv
`timescale 1ns/1ps
module cfgport_globals
  import cfgport_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h5A17,
  parameter logic [7:0]  REV_ID = 8'h03,
  parameter logic [15:0] MFG_ID = 16'h1934
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rd_byte,
  output logic                   hit,
  output logic [7:0]             ldsel,
  output logic [NUM_MUX*8-1:0]   mux_flat
);
  logic [7:0] mux_q [NUM_MUX];
  logic       mux_hit, id_hit;
  logic [7:0] moff;

  assign mux_hit = in_span(idx, int'(IDX_MUX_LO), int'(IDX_MUX_HI));
  assign id_hit  = in_span(idx, int'(IDX_ID_LO), int'(IDX_ID_HI));
  assign hit     = mux_hit || id_hit || (idx == IDX_LDSEL);
  assign moff    = idx - IDX_MUX_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldsel <= '0;
      for (int i = 0; i < NUM_MUX; i++) mux_q[i] <= '0;
    end else if (wr_en) begin
      if (idx == IDX_LDSEL) ldsel <= wdata;
      for (int i = 0; i < NUM_MUX; i++)
        if (mux_hit && int'(moff) == i) mux_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_byte = 8'hFF;
    if (idx == IDX_LDSEL) rd_byte = ldsel;
    else if (id_hit)      rd_byte = id_byte(idx, DEV_ID, REV_ID, MFG_ID);
    else if (mux_hit)
      for (int i = 0; i < NUM_MUX; i++)
        if (int'(moff) == i) rd_byte = mux_q[i];
  end

  for (genvar g = 0; g < NUM_MUX; g++) begin : g_mux
    assign mux_flat[g*8 +: 8] = mux_q[g];
  end
endmodule

// File: rtl/cfgport_devbank.sv
`timescale 1ns/1ps
module cfgport_devbank
  import cfgport_pkg::*;
#(
  parameter int NUM_DEV  = 8,
  parameter int NUM_PRIV = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    ldsel,
  input  logic [7:0]                    idx,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rd_byte,
  output logic                          hit,
  output logic [NUM_DEV-1:0]            en_flat,
  output logic [NUM_DEV*16-1:0]         base_flat,
  output logic [NUM_DEV*NUM_PRIV*8-1:0] priv_flat
);
  logic             en_q   [NUM_DEV];
  logic [15:0]      base_q [NUM_DEV];
  logic [7:0]       priv_q [NUM_DEV][NUM_PRIV];
  logic             dev_ok, priv_hit, reg_hit;
  logic [7:0]       poff;

  assign dev_ok   = int'(ldsel) < NUM_DEV;
  assign priv_hit = in_span(idx, int'(IDX_PRIV_LO), int'(IDX_PRIV_LO) + NUM_PRIV - 1);
  assign reg_hit  = (idx == IDX_DEV_EN) || (idx == IDX_BASE_H) || (idx == IDX_BASE_L) || priv_hit;
  assign hit      = dev_ok && reg_hit;
  assign poff     = idx - IDX_PRIV_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        en_q[d]   <= 1'b0;
        base_q[d] <= '0;
        for (int p = 0; p < NUM_PRIV; p++) priv_q[d][p] <= '0;
      end
    end else if (wr_en && hit) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (int'(ldsel) == d) begin
          if (idx == IDX_DEV_EN) en_q[d]         <= wdata[0];
          if (idx == IDX_BASE_H) base_q[d][15:8] <= wdata;
          if (idx == IDX_BASE_L) base_q[d][7:0]  <= wdata;
          for (int p = 0; p < NUM_PRIV; p++)
            if (priv_hit && int'(poff) == p) priv_q[d][p] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rd_byte = 8'hFF;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (hit && int'(ldsel) == d) begin
        if (idx == IDX_DEV_EN)      rd_byte = {7'b0, en_q[d]};
        else if (idx == IDX_BASE_H) rd_byte = base_q[d][15:8];
        else if (idx == IDX_BASE_L) rd_byte = base_q[d][7:0];
        else
          for (int p = 0; p < NUM_PRIV; p++)
            if (int'(poff) == p) rd_byte = priv_q[d][p];
      end
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign en_flat[d]            = en_q[d];
    assign base_flat[d*16 +: 16] = base_q[d];
    for (genvar p = 0; p < NUM_PRIV; p++) begin : g_priv
      assign priv_flat[(d*NUM_PRIV+p)*8 +: 8] = priv_q[d][p];
    end
  end
endmodule

// File: rtl/cfgport_regfile.sv
`timescale 1ns/1ps
module cfgport_regfile
  import cfgport_pkg::*;
#(
  parameter bit          USE_ALT_BASE = 1'b0,
  parameter int          NUM_DEV      = 8,
  parameter int          NUM_PRIV     = 8,
  parameter logic [15:0] DEV_ID       = 16'h5A17,
  parameter logic [7:0]  REV_ID       = 8'h03,
  parameter logic [15:0] MFG_ID       = 16'h1934
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   io_addr,
  input  logic                          io_wr,
  input  logic                          io_rd,
  input  logic [7:0]                    io_wdata,
  output logic [7:0]                    io_rdata,
  output logic                          io_rd_valid,
  output logic                          cfg_open,
  output logic [7:0]                    ldev_sel,
  output logic [NUM_MUX*8-1:0]          mux_regs,
  output logic [NUM_DEV-1:0]            dev_enable,
  output logic [NUM_DEV*16-1:0]         dev_base,
  output logic [NUM_DEV*NUM_PRIV*8-1:0] dev_priv
);
  localparam logic [15:0] BASE = USE_ALT_BASE ? 16'h004E : 16'h002E;

  // named events
  logic       at_idx, at_dat, idx_wr, dat_wr, locked_dat_wr, rd_port;
  logic       key_hit, exit_hit, idx_load;
  logic [7:0] index_q, glob_rd, dev_rd, rd_next;
  logic       glob_hit, dev_hit;

  assign at_idx        = (io_addr == BASE);
  assign at_dat        = (io_addr == BASE + 16'd1);
  assign idx_wr        = io_wr && at_idx;
  assign dat_wr        = io_wr && at_dat && cfg_open;
  assign locked_dat_wr = io_wr && at_dat && !cfg_open;
  assign rd_port       = io_rd && (at_idx || at_dat);

  cfgport_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .open(cfg_open), .key_hit(key_hit), .exit_hit(exit_hit), .idx_load(idx_load)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        index_q <= '0;
    else if (idx_load) index_q <= io_wdata;

  cfgport_globals #(.DEV_ID(DEV_ID), .REV_ID(REV_ID), .MFG_ID(MFG_ID)) u_glob (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .idx(index_q), .wdata(io_wdata),
    .rd_byte(glob_rd), .hit(glob_hit), .ldsel(ldev_sel), .mux_flat(mux_regs)
  );

  cfgport_devbank #(.NUM_DEV(NUM_DEV), .NUM_PRIV(NUM_PRIV)) u_dev (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .ldsel(ldev_sel), .idx(index_q),
    .wdata(io_wdata), .rd_byte(dev_rd), .hit(dev_hit), .en_flat(dev_enable),
    .base_flat(dev_base), .priv_flat(dev_priv)
  );

  always_comb begin
    rd_next = 8'hFF;
    if (cfg_open) begin
      if (at_idx)        rd_next = index_q;
      else if (glob_hit) rd_next = glob_rd;
      else if (dev_hit)  rd_next = dev_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata    <= 8'hFF;
      io_rd_valid <= 1'b0;
    end else begin
      io_rd_valid <= rd_port;
      if (rd_port) io_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/cfgport_chk.sv
`timescale 1ns/1ps
module cfgport_chk #(
  parameter int NUM_DEV = 8,
  parameter int MUXW    = 56
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_open,
  input logic                 locked_dat_wr,
  input logic                 rd_port,
  input logic                 key_hit,
  input logic                 exit_hit,
  input logic                 io_rd_valid,
  input logic [7:0]           io_rdata,
  input logic [NUM_DEV-1:0]   dev_enable,
  input logic [NUM_DEV*16-1:0] dev_base,
  input logic [MUXW-1:0]      mux_regs
);
  // R2
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_dat_wr |=> $stable(dev_enable) && $stable(dev_base) && $stable(mux_regs));
  // R2
  locked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_port && !cfg_open |=> io_rdata == 8'hFF);
  // R3
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open && !key_hit |=> !cfg_open);
  // R4
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !cfg_open);
  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_port |=> io_rd_valid);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_port |=> !io_rd_valid);
endmodule

bind cfgport_regfile cfgport_chk #(.NUM_DEV(NUM_DEV), .MUXW(cfgport_pkg::NUM_MUX*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .locked_dat_wr(locked_dat_wr),
  .rd_port(rd_port), .key_hit(key_hit), .exit_hit(exit_hit),
  .io_rd_valid(io_rd_valid), .io_rdata(io_rdata), .dev_enable(dev_enable),
  .dev_base(dev_base), .mux_regs(mux_regs)
);

// File: tb/sim_cfgport_regfile.sv
`timescale 1ns/1ps
module sim_cfgport_regfile;
  localparam int ND = 8, NP = 8;
  localparam logic [15:0] IP = 16'h002E, DP = 16'h002F;

  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        io_rd_valid, cfg_open;
  logic [7:0]  ldev_sel;
  logic [55:0] mux_regs;
  logic [ND-1:0] dev_enable;
  logic [ND*16-1:0] dev_base;
  logic [ND*NP*8-1:0] dev_priv;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cfgport_regfile u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each returned byte
  always @(negedge clk) begin
    if (rst_n && io_rd_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected valid", 1, 0);
      else chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
    end
  end

  task automatic iowr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask
  task automatic iord(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0;
  endtask
  task automatic unlock(); iowr(IP, 8'h87); iowr(IP, 8'h87); endtask
  task automatic cw(input logic [7:0] i, input logic [7:0] d); iowr(IP, i); iowr(DP, d); endtask
  task automatic cr(input logic [7:0] i, input logic [7:0] e, input string tag);
    iowr(IP, i); iord(DP, e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 open", cfg_open, 0);
    chk("R1 sel", ldev_sel, 0);
    chk("R1 mux", mux_regs, 0);
    chk("R1 en", dev_enable, 0);
    chk("R1 base", dev_base[63:0], 0);
    // R2 locked reads
    iord(DP, 8'hFF, "R2 locked data read");
    iord(IP, 8'hFF, "R2 locked index read");
    // R2 locked write ignored
    unlock(); iowr(IP, 8'h26); iowr(IP, 8'hAA);
    iowr(DP, 8'h5A);
    chk("R2 locked write", mux_regs, 0);
    // R3 broken sequence
    iowr(IP, 8'h87); iowr(IP, 8'h11); iowr(IP, 8'h87);
    chk("R3 broken key", cfg_open, 0);
    iowr(IP, 8'h87);
    chk("R3 open", cfg_open, 1);
    iowr(IP, 8'h22);
    iord(IP, 8'h22, "R2 index readback");
    // R5 identification
    cr(8'h20, 8'h5A, "R5 id hi"); cr(8'h21, 8'h17, "R5 id lo");
    cr(8'h22, 8'h03, "R5 rev"); cr(8'h23, 8'h19, "R5 mfg hi");
    cr(8'h24, 8'h34, "R5 mfg lo");
    cw(8'h20, 8'h00); cr(8'h20, 8'h5A, "R5 ro");
    // R9 shared pin routing
    cw(8'h29, 8'hEF); cw(8'h2B, 8'hDF);
    chk("R9 mux", mux_regs, 56'h00DF00EF000000);
    cw(8'h07, 8'h03); cr(8'h29, 8'hEF, "R9 shared under sel3");
    // R6 R7 R8 banks
    cw(8'h07, 8'h07); cw(8'h30, 8'hFF);
    chk("R7 enable", dev_enable, 8'h80);
    cr(8'h30, 8'h01, "R7 readback");
    cw(8'h60, 8'h12); cw(8'h61, 8'h34);
    chk("R8 base", dev_base[7*16 +: 16], 16'h1234);
    cw(8'hF5, 8'h40);
    chk("R10 priv", dev_priv[(7*NP+5)*8 +: 8], 8'h40);
    cw(8'h07, 8'h02);
    cr(8'h07, 8'h02, "R6 sel readback");
    cr(8'h30, 8'h00, "R6 dev2 enable");
    cr(8'hF5, 8'h00, "R6 dev2 priv");
    cw(8'h60, 8'hAB);
    chk("R8 dev2 base", dev_base[2*16 +: 16], 16'hAB00);
    cw(8'h07, 8'h07);
    cr(8'h60, 8'h12, "R6 dev7 kept");
    // R10 out-of-range selector and unmapped index
    cw(8'h07, 8'h09);
    cr(8'h30, 8'hFF, "R10 bad sel read");
    cw(8'h30, 8'h01);
    chk("R10 bad sel write", dev_enable, 8'h80);
    cr(8'h50, 8'hFF, "R10 unmapped");
    // R11 read and write together
    cw(8'h2A, 8'h11);
    exp_q.push_back(8'h11); tag_q.push_back("R11 rd+wr old");
    io_addr = DP; io_wdata = 8'h22; io_wr = 1; io_rd = 1;
    @(negedge clk); io_wr = 0; io_rd = 0;
    chk("R11 new value", mux_regs[4*8 +: 8], 8'h22);
    iord(DP, 8'h22, "R11 readback");
    // R12 foreign addresses
    iowr(16'h0030, 8'hAA);
    chk("R12 no lock", cfg_open, 1);
    iowr(IP, 8'h26); iowr(16'h0080, 8'h77);
    chk("R12 no write", mux_regs[7:0], 0);
    // R4 exit key
    iowr(IP, 8'hAA);
    chk("R4 closed", cfg_open, 0);
    iord(DP, 8'hFF, "R4 closed read");
    iowr(16'h004E, 8'h87); iowr(16'h004E, 8'h87);
    chk("R12 alt base keys ignored", cfg_open, 0);
    unlock();
    iord(IP, 8'h26, "R4 index kept");
    repeat (3) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule